// File: doc/BRIEF.md
# PWM Fault Guard and Output Override

This block sits between the raw complementary outputs of a multi-channel PWM generator and the pads. It watches a set of fault inputs and, when any fault enabled for a channel is present, it forces that channel's high-side and low-side outputs to a programmed safe state: driven low, driven high, or released (output enable deasserted). The fault path is purely combinational from the fault pin to the output pins, so the safe state appears without waiting for any clock edge. Each fault is also latched, so the safe state persists until the fault input has returned to its inactive level and software clears the latch.

Below the fault path sits a software override that forces selected outputs to chosen levels. An override written in immediate mode takes effect on the next clock; one written in boundary mode is staged and copied into each channel's outputs only when that channel's counter wraps. A write-protect switch locks the fault polarity, fault-to-channel mask and safe-state registers; writes to them while locked are dropped and flagged.

Configuration arrives through a simple write port (`cfg_we`, `cfg_addr`, `cfg_wdata`).

Top module: `pwmf_guard`

## Requirements
- R1: After reset every pin follows its raw PWM input with output enable high, no fault latch is set, the violation flag is low, all fault polarities are active-high, and no fault is routed to any channel.
- R2: Fault input f is active when its level equals bit f of the polarity register (address 0); 1 means active-high, 0 means active-low.
- R3: Fault f affects channel c only when bit c*NUM_FLT+f of the mask register (address 1) is set; channels without a set bit for an active fault keep their normal output.
- R4: The safe state is applied in the same cycle a fault input becomes active, before any clock edge.
- R5: The safe-state register (address 2) holds a 2-bit code per pin at bits [2o+1:2o], where pin o=2c is channel c's high side and o=2c+1 its low side; code 00 drives 0, 01 drives 1, 1x releases the pin (enable 0, data 0).
- R6: An active fault sets its latch bit (reported on `fault_latched`) at the next clock; the latch keeps the channel in its safe state after the input returns inactive, and is cleared only by writing 1 to bit f of address 4 while the input is inactive; a clear while active is ignored.
- R7: Writing address 3 with bit 2*NUM_OUT = 0 (immediate mode) makes every pin o whose select bit o is set drive value bit NUM_OUT+o, from the cycle after the write; pins with select 0 return to normal.
- R8: Writing address 3 with bit 2*NUM_OUT = 1 (boundary mode) stages the select and value bits; channel c's two pins adopt the staged setting in the cycle after `cnt_wrap[c]` is high, and not before.
- R9: A channel in fault shows its safe state regardless of override; an overridden pin shows its override value regardless of the PWM input.
- R10: Writing address 5 sets the write lock from bit 0 and clears the violation flag when bit 1 is 1; while locked, writes to addresses 0, 1 and 2 leave those registers unchanged and set `wp_viol` at the next clock; addresses 3, 4 and 5 are always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration, latches and override staging |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_h | input | NUM_CH | Raw high-side PWM level per channel |
| pwm_l | input | NUM_CH | Raw low-side PWM level per channel |
| cnt_wrap | input | NUM_CH | One-cycle pulse when a channel's counter wraps to zero |
| fault_in | input | NUM_FLT | Fault pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| pin_out | output | 2*NUM_CH | Pin data, index 2c high side, 2c+1 low side |
| pin_oe | output | 2*NUM_CH | Pin output enable, 0 means released |
| fault_latched | output | NUM_FLT | Latched fault status |
| wp_viol | output | 1 | Sticky flag for a write dropped by the lock |

## Verification
A wrong fault latch shows at the pins as a channel that stays in its safe state after the fault input clears, or that leaves it too early, and on `fault_latched` one clock after the input goes active. A corrupt mask, polarity or safe-code register shows in the same cycle a fault is applied, since the fault path has no register; a stale or early override copy shows on the cycle after a counter wrap or a write. Because the pins are compared every cycle against a model, any such state error is seen within one cycle of the stimulus that exposes it.

// File: rtl/pwmf_pkg.sv
// Package: shared register addresses and safe-state codes for the
// PWM fault guard. Assumes a 3-bit configuration address space.
package pwmf_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_POL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_SAFE = 3'd2;
    localparam logic [ADDR_W-1:0] A_OVR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LOCK = 3'd5;

    typedef enum logic [1:0] {
        SAFE_LOW  = 2'b00,
        SAFE_HIGH = 2'b01,
        SAFE_REL  = 2'b10,
        SAFE_REL2 = 2'b11
    } safe_code_e;

    // True for addresses guarded by the write lock.
    function automatic logic is_locked_addr(input logic [ADDR_W-1:0] a);
        return (a == A_POL) || (a == A_MASK) || (a == A_SAFE);
    endfunction
endpackage

// File: rtl/pwmf_regs.sv
// Module: configuration registers with write lock.
// Holds fault polarity, fault-to-channel mask, safe codes and the lock.
// Passes override and latch-clear writes through as single-cycle strobes.
// Assumes NUM_CH*NUM_FLT and 4*NUM_CH fit in DATA_W.
module pwmf_regs
    import pwmf_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_FLT = 8,
    parameter int DATA_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [NUM_FLT-1:0]          pol_q,
    output logic [NUM_CH*NUM_FLT-1:0]   mask_q,
    output logic [4*NUM_CH-1:0]         safe_q,
    output logic                        viol_q,
    output logic                        ovr_we,
    output logic                        clr_we,
    output logic [NUM_FLT-1:0]          clr_mask
);
    localparam int MASK_W = NUM_CH * NUM_FLT;
    localparam int SAFE_W = 4 * NUM_CH;

    logic lock_q;
    logic wr_locked;

    // Decode a write that targets a guarded register while locked.
    always_comb begin
        wr_locked = cfg_we && lock_q && is_locked_addr(cfg_addr);
    end

    // Strobes for the unguarded action registers.
    always_comb begin
        ovr_we   = cfg_we && (cfg_addr == A_OVR);
        clr_we   = cfg_we && (cfg_addr == A_CLR);
        clr_mask = cfg_wdata[NUM_FLT-1:0];
    end

    // Register file update with lock and violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '1;
            mask_q <= '0;
            safe_q <= '0;
            lock_q <= 1'b0;
            viol_q <= 1'b0;
        end else if (cfg_we) begin
            if (wr_locked) begin
                viol_q <= 1'b1;
            end else begin
                case (cfg_addr)
                    A_POL:  pol_q  <= cfg_wdata[NUM_FLT-1:0];
                    A_MASK: mask_q <= cfg_wdata[MASK_W-1:0];
                    A_SAFE: safe_q <= cfg_wdata[SAFE_W-1:0];
                    A_LOCK: begin
                        lock_q <= cfg_wdata[0];
                        if (cfg_wdata[1]) viol_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock_q && is_locked_addr(cfg_addr))
        |=> ($stable(pol_q) && $stable(mask_q) && $stable(safe_q)));

    // R10
    lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock_q && is_locked_addr(cfg_addr)) |=> viol_q);
endmodule

// File: rtl/pwmf_fault.sv
// Module: fault detection, latching and per-channel fault decision.
// The channel fault flag is combinational from the fault pins so the
// safe state needs no clock; the latch only extends it afterwards.
module pwmf_fault #(
    parameter int NUM_CH  = 4,
    parameter int NUM_FLT = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FLT-1:0]          fault_in,
    input  logic [NUM_FLT-1:0]          pol_q,
    input  logic [NUM_CH*NUM_FLT-1:0]   mask_q,
    input  logic                        clr_we,
    input  logic [NUM_FLT-1:0]          clr_mask,
    output logic [NUM_FLT-1:0]          latch_q,
    output logic [NUM_CH-1:0]           ch_fault
);
    logic [NUM_FLT-1:0] raw_act;
    logic [NUM_FLT-1:0] hit;

    // Polarity-corrected fault level, merged with the latch.
    always_comb begin
        raw_act = ~(fault_in ^ pol_q);
        hit     = raw_act | latch_q;
    end

    for (genvar f = 0; f < NUM_FLT; f++) begin : g_latch
        // Set on an active fault, clear only when inactive and asked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_q[f] <= 1'b0;
            else if (raw_act[f])
                latch_q[f] <= 1'b1;
            else if (clr_we && clr_mask[f])
                latch_q[f] <= 1'b0;
        end

        // R6
        latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            raw_act[f] |=> latch_q[f]);

        // R6
        latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(latch_q[f]) |-> $past(clr_we && clr_mask[f] && !raw_act[f]));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        // A channel is in fault when any routed fault is present.
        always_comb begin
            ch_fault[c] = |(hit & mask_q[c*NUM_FLT +: NUM_FLT]);
        end
    end
endmodule

// File: rtl/pwmf_override.sv
// Module: software override staging and application.
// Immediate-mode writes load the active override directly; boundary-mode
// writes wait in a staging register until each channel's counter wraps.
// Assumes the write data holds select bits, then value bits, then mode.
module pwmf_override #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ovr_we,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NUM_CH-1:0]       cnt_wrap,
    output logic [2*NUM_CH-1:0]     act_sel,
    output logic [2*NUM_CH-1:0]     act_val
);
    localparam int NUM_OUT  = 2 * NUM_CH;
    localparam int MODE_BIT = 2 * NUM_OUT;

    logic [NUM_OUT-1:0] stg_sel;
    logic [NUM_OUT-1:0] stg_val;
    logic               imm_load;

    // Immediate load when the mode bit of the write is clear.
    always_comb begin
        imm_load = ovr_we && !wdata[MODE_BIT];
    end

    // Staging register captures every override write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_sel <= '0;
            stg_val <= '0;
        end else if (ovr_we) begin
            stg_sel <= wdata[NUM_OUT-1:0];
            stg_val <= wdata[2*NUM_OUT-1:NUM_OUT];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_act
        // Active override per channel: immediate write first, then wrap copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_sel[2*c +: 2] <= '0;
                act_val[2*c +: 2] <= '0;
            end else if (imm_load) begin
                act_sel[2*c +: 2] <= wdata[2*c +: 2];
                act_val[2*c +: 2] <= wdata[NUM_OUT + 2*c +: 2];
            end else if (cnt_wrap[c]) begin
                act_sel[2*c +: 2] <= stg_sel[2*c +: 2];
                act_val[2*c +: 2] <= stg_val[2*c +: 2];
            end
        end

        // R8
        sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_wrap[c] && !imm_load)
            |=> ($stable(act_sel[2*c +: 2]) && $stable(act_val[2*c +: 2])));
    end
endmodule

// File: rtl/pwmf_outmux.sv
// Module: per-pin priority multiplexer.
// Fault safe state first, then software override, then raw PWM.
// A released pin has enable 0 and data 0.
module pwmf_outmux
    import pwmf_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*NUM_CH-1:0]     pwm_raw,
    input  logic [NUM_CH-1:0]       ch_fault,
    input  logic [4*NUM_CH-1:0]     safe_q,
    input  logic [2*NUM_CH-1:0]     act_sel,
    input  logic [2*NUM_CH-1:0]     act_val,
    output logic [2*NUM_CH-1:0]     pin_out,
    output logic [2*NUM_CH-1:0]     pin_oe
);
    localparam int NUM_OUT = 2 * NUM_CH;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_pin
        localparam int CH = o / 2;
        safe_code_e code;

        // Pick the pin level by priority.
        always_comb begin
            code = safe_code_e'(safe_q[2*o +: 2]);
            if (ch_fault[CH]) begin
                pin_out[o] = (code == SAFE_HIGH);
                pin_oe[o]  = (code == SAFE_LOW) || (code == SAFE_HIGH);
            end else if (act_sel[o]) begin
                pin_out[o] = act_val[o];
                pin_oe[o]  = 1'b1;
            end else begin
                pin_out[o] = pwm_raw[o];
                pin_oe[o]  = 1'b1;
            end
        end

        // R5
        release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_fault[CH] && safe_q[2*o+1]) |-> (!pin_oe[o] && !pin_out[o]));

        // R9
        ovr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_fault[CH] && act_sel[o]) |-> (pin_oe[o] && (pin_out[o] == act_val[o])));

        // R1
        pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_fault[CH] && !act_sel[o]) |-> (pin_oe[o] && (pin_out[o] == pwm_raw[o])));
    end
endmodule

// File: rtl/pwmf_guard.sv
// Module: top of the PWM fault guard.
// Wires registers, fault unit, override unit and pin multiplexer.
// Assumes DATA_W >= 4*NUM_CH+1 and DATA_W >= NUM_CH*NUM_FLT.
module pwmf_guard
    import pwmf_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_FLT = 8,
    parameter int DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       pwm_h,
    input  logic [NUM_CH-1:0]       pwm_l,
    input  logic [NUM_CH-1:0]       cnt_wrap,
    input  logic [NUM_FLT-1:0]      fault_in,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [DATA_W-1:0]       cfg_wdata,
    output logic [2*NUM_CH-1:0]     pin_out,
    output logic [2*NUM_CH-1:0]     pin_oe,
    output logic [NUM_FLT-1:0]      fault_latched,
    output logic                    wp_viol
);
    localparam int NUM_OUT = 2 * NUM_CH;

    logic [NUM_FLT-1:0]         pol_q;
    logic [NUM_CH*NUM_FLT-1:0]  mask_q;
    logic [2*NUM_OUT-1:0]       safe_q;
    logic                       ovr_we;
    logic                       clr_we;
    logic [NUM_FLT-1:0]         clr_mask;
    logic [NUM_CH-1:0]          ch_fault;
    logic [NUM_OUT-1:0]         act_sel;
    logic [NUM_OUT-1:0]         act_val;
    logic [NUM_OUT-1:0]         pwm_raw;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_raw
        // Interleave high and low sides into pin order.
        always_comb begin
            pwm_raw[2*c]   = pwm_h[c];
            pwm_raw[2*c+1] = pwm_l[c];
        end
    end

    pwmf_regs #(.NUM_CH(NUM_CH), .NUM_FLT(NUM_FLT), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pol_q(pol_q), .mask_q(mask_q), .safe_q(safe_q),
        .viol_q(wp_viol), .ovr_we(ovr_we), .clr_we(clr_we), .clr_mask(clr_mask)
    );

    pwmf_fault #(.NUM_CH(NUM_CH), .NUM_FLT(NUM_FLT)) u_fault (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .pol_q(pol_q),
        .mask_q(mask_q), .clr_we(clr_we), .clr_mask(clr_mask),
        .latch_q(fault_latched), .ch_fault(ch_fault)
    );

    pwmf_override #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ovr (
        .clk(clk), .rst_n(rst_n), .ovr_we(ovr_we), .wdata(cfg_wdata),
        .cnt_wrap(cnt_wrap), .act_sel(act_sel), .act_val(act_val)
    );

    pwmf_outmux #(.NUM_CH(NUM_CH)) u_mux (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .ch_fault(ch_fault),
        .safe_q(safe_q), .act_sel(act_sel), .act_val(act_val),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: tb/sim_pwmf_guard.sv
module sim_pwmf_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NF  = 8;
    localparam int NO  = 2 * NCH;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              rst_n;
    logic [NCH-1:0]    pwm_h, pwm_l, cnt_wrap;
    logic [NF-1:0]     fault_in;
    logic              cfg_we;
    logic [2:0]        cfg_addr;
    logic [31:0]       cfg_wdata;
    logic [NO-1:0]     pin_out, pin_oe;
    logic [NF-1:0]     fault_latched;
    logic              wp_viol;

    // next-cycle stimulus
    logic              n_rst;
    logic [NCH-1:0]    n_h, n_l, n_wrap;
    logic [NF-1:0]     n_flt;
    logic              n_we;
    logic [2:0]        n_addr;
    logic [31:0]       n_wd;

    // model state
    logic [NF-1:0]     m_pol, m_latch;
    logic [31:0]       m_mask;
    logic [15:0]       m_safe;
    logic [NO-1:0]     m_asel, m_aval, m_ssel, m_sval;
    logic              m_lock, m_viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    pwmf_guard u0 (
        .clk(clk), .rst_n(rst_n), .pwm_h(pwm_h), .pwm_l(pwm_l),
        .cnt_wrap(cnt_wrap), .fault_in(fault_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pin_out(pin_out),
        .pin_oe(pin_oe), .fault_latched(fault_latched), .wp_viol(wp_viol)
    );

    function automatic logic [NCH-1:0] chan_fault(input logic [NF-1:0] fi);
        logic [NF-1:0] hit;
        hit = ~(fi ^ m_pol) | m_latch;
        for (int c = 0; c < NCH; c++) chan_fault[c] = |(hit & m_mask[c*NF +: NF]);
    endfunction

    function automatic logic [2*NO-1:0] exp_pins(input logic [NF-1:0] fi,
                                                  input logic [NCH-1:0] h,
                                                  input logic [NCH-1:0] l);
        logic [NCH-1:0] cf;
        logic [NO-1:0] o, e;
        cf = chan_fault(fi);
        for (int p = 0; p < NO; p++) begin
            if (cf[p/2]) begin
                o[p] = (m_safe[2*p +: 2] == 2'b01);
                e[p] = !m_safe[2*p+1];
            end else if (m_asel[p]) begin
                o[p] = m_aval[p]; e[p] = 1'b1;
            end else begin
                o[p] = (p % 2 == 0) ? h[p/2] : l[p/2]; e[p] = 1'b1;
            end
        end
        return {e, o};
    endfunction

    task automatic model_update();
        logic [NF-1:0] raw;
        if (!rst_n) begin
            m_pol = '1; m_latch = '0; m_mask = '0; m_safe = '0;
            m_asel = '0; m_aval = '0; m_ssel = '0; m_sval = '0;
            m_lock = 0; m_viol = 0;
            return;
        end
        raw = ~(fault_in ^ m_pol);
        for (int f = 0; f < NF; f++) begin
            if (raw[f]) m_latch[f] = 1'b1;
            else if (cfg_we && cfg_addr == 3'd4 && cfg_wdata[f]) m_latch[f] = 1'b0;
        end
        for (int c = 0; c < NCH; c++)
            if (cnt_wrap[c]) begin
                m_asel[2*c +: 2] = m_ssel[2*c +: 2];
                m_aval[2*c +: 2] = m_sval[2*c +: 2];
            end
        if (cfg_we) begin
            if (m_lock && cfg_addr <= 3'd2) m_viol = 1'b1;
            else case (cfg_addr)
                3'd0: m_pol  = cfg_wdata[NF-1:0];
                3'd1: m_mask = cfg_wdata;
                3'd2: m_safe = cfg_wdata[15:0];
                3'd3: begin
                    m_ssel = cfg_wdata[7:0]; m_sval = cfg_wdata[15:8];
                    if (!cfg_wdata[16]) begin
                        m_asel = cfg_wdata[7:0]; m_aval = cfg_wdata[15:8];
                    end
                end
                3'd5: begin
                    m_lock = cfg_wdata[0];
                    if (cfg_wdata[1]) m_viol = 1'b0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic step(input string tag);
        logic [2*NO-1:0] ex;
        @(negedge clk);
        rst_n = n_rst; pwm_h = n_h; pwm_l = n_l; cnt_wrap = n_wrap;
        fault_in = n_flt; cfg_we = n_we; cfg_addr = n_addr; cfg_wdata = n_wd;
        #1;
        if (rst_n && tag != "") begin
            ex = exp_pins(fault_in, pwm_h, pwm_l);
            checks++;
            if (pin_out !== ex[NO-1:0] || pin_oe !== ex[2*NO-1:NO] ||
                fault_latched !== m_latch || wp_viol !== m_viol) begin
                fails++;
                $display("FAIL %s: out=%h oe=%h lat=%h viol=%b expected out=%h oe=%h lat=%h viol=%b",
                         tag, pin_out, pin_oe, fault_latched, wp_viol,
                         ex[NO-1:0], ex[2*NO-1:NO], m_latch, m_viol);
            end
        end
        @(posedge clk);
        model_update();
        n_we = 0; n_wrap = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        n_we = 1; n_addr = a; n_wd = d;
        step(tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        n_rst = 0; n_h = '0; n_l = '0; n_wrap = '0; n_flt = '0;
        n_we = 0; n_addr = '0; n_wd = '0;
        repeat (3) step("");
        n_rst = 1;
        // R1 reset state and pass-through
        for (int i = 0; i < 8; i++) begin
            n_h = 4'($urandom); n_l = 4'($urandom); n_flt = 8'($urandom);
            step("R1");
        end
        n_flt = '0;
        // R5 safe codes: pin0=01 pin1=10 pin2=00 pin3=11 pin4=01 pin5=00
        wr(3'd2, 32'h0000_01C9, "R5");
        // R3 mask: ch0<-f0, ch1<-f3, ch2<-f5
        wr(3'd1, 32'h0020_0801, "R3");
        n_h = 4'hF; n_l = 4'hF;
        // R4 fault applies with no clock edge
        n_flt = 8'h01; step("R4");
        step("R6");
        n_flt = 8'h00; step("R6");           // latched, still in safe state
        wr(3'd4, 32'h01, "R6");              // clear while inactive
        step("R6");
        // R6 clear while active is ignored
        n_flt = 8'h08; step("R4");
        wr(3'd4, 32'h08, "R6");
        step("R6");
        n_flt = 8'h00; step("R6");
        wr(3'd4, 32'h08, "R6");
        step("R6");
        // R3 unrouted fault has no effect
        n_flt = 8'hC6; step("R3");
        n_flt = 8'h00; step("R3");
        // R2 active-low fault 5
        wr(3'd0, 32'h0000_00DF, "R2");
        step("R2");
        n_flt = 8'h20; step("R2");
        wr(3'd4, 32'h20, "R2");
        wr(3'd0, 32'h0000_00FF, "R2");
        wr(3'd4, 32'h20, "R2");
        step("R2");
        // R7 immediate override: pins 1,6 forced, values 0x40
        n_h = 4'h5; n_l = 4'hA;
        wr(3'd3, 32'h0000_4042, "R7");
        step("R7");
        wr(3'd3, 32'h0000_0000, "R7");
        step("R7");
        // R8 boundary override on pins 0,2,4,6 -> 1
        wr(3'd3, 32'h0001_5555, "R8");
        step("R8");
        n_wrap = 4'b0010; step("R8");
        step("R8");
        n_wrap = 4'b1101; step("R8");
        step("R8");
        // R9 fault beats override
        n_flt = 8'h01; step("R9");
        n_flt = 8'h00; step("R9");
        wr(3'd4, 32'hFF, "R9");
        step("R9");
        // R10 lock
        wr(3'd5, 32'h1, "R10");
        wr(3'd1, 32'h0000_00FF, "R10");      // dropped
        n_flt = 8'h02; step("R10");          // fault 1 still unrouted
        n_flt = 8'h00;
        wr(3'd2, 32'hFFFF, "R10");
        wr(3'd3, 32'h0000_0000, "R10");      // always writable
        step("R10");
        wr(3'd5, 32'h2, "R10");              // unlock, clear flag
        step("R10");
        // random mix
        for (int i = 0; i < 400; i++) begin
            n_h = 4'($urandom); n_l = 4'($urandom);
            n_wrap = 4'($urandom) & 4'($urandom);
            n_flt = (($urandom % 4) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            if (($urandom % 5) == 0) begin
                n_we = 1; n_addr = 3'($urandom % 6);
                n_wd = $urandom;
                if (n_addr == 3'd0) n_wd[7:0] = 8'hFF ^ 8'(($urandom % 3 == 0) << ($urandom % 8));
            end
            step("R9");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule